// File: doc/BRIEF.md
# Pipelined Circular Coordinate Rotator

This block is a fully unrolled shift-and-add rotator in circular coordinates. It takes one sample (x, y, z) per clock and returns one result per clock after a fixed delay. Each sample carries a mode bit that selects one of two operations. In rotate mode the vector (x, y) is turned through the angle z. In vector mode the vector is turned onto the positive x axis, and the angle used to do so is collected in z.

The chain has two parts. The first part holds the micro-rotation stages. Stage i shifts by a fixed amount i and uses a constant angle atan(2^-i), which is worked out during elaboration. The second part holds the gain-correction stages. Each of these multiplies both coordinates by (1 ± 2^-k) with a fixed k. A register separates every pair of adjacent stages. The valid bit and the mode bit travel in step with the data. Inside the chain, two extra integer bits keep full-scale inputs from overflowing, and low fraction bits limit the loss from truncation.

Angles are signed two's complement. A code of 2^(ANGLE_W-1) stands for pi radians.

Top module: `cordic_pipe_array`

## Requirements
- R1: A synchronous active-low reset clears every valid bit in the chain. While reset is low, and after it is released until new samples have passed through the chain, `valid_o` stays 0. No sample that entered before the reset ever comes out.
- R2: A sample captured with `valid_i`=1 at a rising edge appears at the outputs with `valid_o`=1 after exactly ROT_STAGES+SCALE_STAGES rising edges, counting the capturing edge. Samples may arrive back to back, and gaps in `valid_i` appear in the same positions at `valid_o`.
- R3: Rotate mode (`mode_i`=0) takes |z_i| ≤ 2^(ANGLE_W-2), which is ±pi/2. With θ = z_i·pi/2^(ANGLE_W-1), x_o equals x·cosθ − y·sinθ and y_o equals y·cosθ + x·sinθ, each within 8 LSB. z_o ends within 4 LSB of 0. Each stage turns toward reducing the remaining angle.
- R4: Vector mode (`mode_i`=1) takes x_i ≥ 0 and z_i = 0. x_o equals sqrt(x²+y²) within 8 LSB, and y_o is within 8 LSB of 0. When the magnitude is at least 1024, z_o equals atan2(y, x) in angle codes within 4 LSB. Each stage turns toward reducing |y|, so x never falls from one stage to the next.
- R5: The mode bit is held separately for each sample. A stream that mixes the two modes back to back gives each sample the result of its own mode.
- R6: The gain-correction stages remove the rotation gain. In rotate mode with z_i = 0, the input vector comes back within 8 LSB.
- R7: Inputs of any magnitude, including the most negative code on both x and y, pass through without internal overflow. The results fit x_o and y_o, which are DATA_W+1 bits wide and use the same LSB weight as the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all stage registers update on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the valid bits |
| valid_i | input | 1 | Marks a sample present on the inputs this cycle |
| mode_i | input | 1 | 0 = rotate by z_i, 1 = vector onto the x axis |
| x_i | input | DATA_W | Signed x coordinate |
| y_i | input | DATA_W | Signed y coordinate |
| z_i | input | ANGLE_W | Signed angle code (2^(ANGLE_W-1) is pi) |
| valid_o | output | 1 | Marks a result present on the outputs |
| x_o | output | DATA_W+1 | Signed x result, same LSB weight as x_i |
| y_o | output | DATA_W+1 | Signed y result, same LSB weight as y_i |
| z_o | output | ANGLE_W | Signed angle result code |

## Verification
The bench uses the default parameters: 16-bit data and angles, 16 micro-rotation stages, six correction stages with shifts 1, 2, 5, 9, 10 and 16, and four guard bits on both the data and the angle paths. That gives a 22-cycle chain. The leftover angle after sixteen stages is well under one output LSB, so tolerances of a few LSB against real trigonometry stay tight. With these widths the bench can also apply the most negative corners and ±pi/2 rotations, and can place a reset in the middle of a full chain.

// File: rtl/cordic_pkg.sv
// Package: shared mode encoding and the elaboration-time elementary angle
// constant used by every micro-rotation stage.
package cordic_pkg;

    typedef enum logic {
        MODE_ROTATE = 1'b0,
        MODE_VECTOR = 1'b1
    } cordic_mode_e;

    localparam real PI_R = 3.14159265358979;

    // Returns round(atan(2^-stage) * 2^(zbits-1) / pi), computed with a power
    // series so that no run-time table is needed.
    function automatic int elem_angle_code(input int stage, input int zbits);
        real t;
        real term;
        real acc;
        real scale;
        if (stage == 0) begin
            acc = PI_R / 4.0;
        end else begin
            t = 1.0;
            for (int k = 0; k < stage; k++) t = t / 2.0;
            acc  = 0.0;
            term = t;
            for (int k = 0; k < 24; k++) begin
                if (k % 2 == 0) acc = acc + term / real'(2 * k + 1);
                else            acc = acc - term / real'(2 * k + 1);
                term = term * t * t;
            end
        end
        scale = 1.0;
        for (int k = 0; k < zbits - 1; k++) scale = scale * 2.0;
        return $rtoi(acc * scale / PI_R + 0.5);
    endfunction

endpackage

// File: rtl/cordic_rot_stage.sv
// Module: one micro-rotation stage of the unrolled chain.
// Applies x' = x -/+ (y >>> SHIFT), y' = y +/- (x >>> SHIFT) and
// z' = z -/+ ANGLE, then registers the result together with valid and mode.
// Assumes the inputs are inside the convergence range given in the brief.
module cordic_rot_stage
    import cordic_pkg::*;
#(
    parameter int W     = 22,
    parameter int ZI    = 20,
    parameter int SHIFT = 0,
    parameter int ANGLE = 131072
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid_i,
    input  cordic_mode_e         mode_i,
    input  logic signed [W-1:0]  x_i,
    input  logic signed [W-1:0]  y_i,
    input  logic signed [ZI-1:0] z_i,
    output logic                 valid_o,
    output cordic_mode_e         mode_o,
    output logic signed [W-1:0]  x_o,
    output logic signed [W-1:0]  y_o,
    output logic signed [ZI-1:0] z_o
);

    localparam logic signed [ZI-1:0] ANG     = ZI'(ANGLE);
    localparam logic        [ZI:0]   ANG_MAG = (ZI+1)'(ANGLE);

    logic                 ccw;
    logic signed [W-1:0]  x_sh;
    logic signed [W-1:0]  y_sh;
    logic signed [W:0]    x_w;
    logic signed [W:0]    y_w;
    logic signed [ZI-1:0] z_n;

    assign x_sh = x_i >>> SHIFT;
    assign y_sh = y_i >>> SHIFT;

    // Chooses the turn direction: residual angle sign, or opposite signs of x and y.
    always_comb begin
        if (mode_i == MODE_ROTATE) ccw = ~z_i[ZI-1];
        else                       ccw = x_i[W-1] ^ y_i[W-1];
    end

    // Forms the shift-and-add update one bit wider than the datapath.
    always_comb begin
        if (ccw) begin
            x_w = {x_i[W-1], x_i} - {y_sh[W-1], y_sh};
            y_w = {y_i[W-1], y_i} + {x_sh[W-1], x_sh};
            z_n = z_i - ANG;
        end else begin
            x_w = {x_i[W-1], x_i} + {y_sh[W-1], y_sh};
            y_w = {y_i[W-1], y_i} - {x_sh[W-1], x_sh};
            z_n = z_i + ANG;
        end
    end

    // Pipeline valid bit, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_o <= 1'b0;
        else        valid_o <= valid_i;
    end

    // Pipeline data register; only qualified by valid downstream.
    always_ff @(posedge clk) begin
        mode_o <= mode_i;
        x_o    <= x_w[W-1:0];
        y_o    <= y_w[W-1:0];
        z_o    <= z_n;
    end

    function automatic logic [ZI:0] zmag(input logic signed [ZI-1:0] v);
        logic signed [ZI:0] e;
        e = {v[ZI-1], v};
        return e[ZI] ? -e : e;
    endfunction

    // R7: the wide sum never needs its extra top bit.
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |-> (x_w[W] == x_w[W-1] && y_w[W] == y_w[W-1]));

    // R3: in rotate mode the residual angle never grows past max(|z|, angle).
    assert_residual_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && mode_i == MODE_ROTATE) |=>
        (zmag(z_o) <= ((zmag($past(z_i)) > ANG_MAG) ? zmag($past(z_i)) : ANG_MAG)));

    // R4: in vector mode with x >= 0 the x coordinate never decreases.
    assert_vector_x_grows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && mode_i == MODE_VECTOR && !x_i[W-1]) |=> (x_o >= $past(x_i)));

endmodule

// File: rtl/cordic_scale_stage.sv
// Module: one gain-correction stage, v' = v +/- (v >>> SHIFT) on x and y.
// The angle, mode and valid pass through unchanged with one register delay.
// Assumes a subtracting stage comes first so magnitudes shrink before growing.
module cordic_scale_stage
    import cordic_pkg::*;
#(
    parameter int W        = 22,
    parameter int ZI       = 20,
    parameter int SHIFT    = 1,
    parameter bit SUBTRACT = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid_i,
    input  cordic_mode_e         mode_i,
    input  logic signed [W-1:0]  x_i,
    input  logic signed [W-1:0]  y_i,
    input  logic signed [ZI-1:0] z_i,
    output logic                 valid_o,
    output cordic_mode_e         mode_o,
    output logic signed [W-1:0]  x_o,
    output logic signed [W-1:0]  y_o,
    output logic signed [ZI-1:0] z_o
);

    logic signed [W-1:0] x_sh;
    logic signed [W-1:0] y_sh;
    logic signed [W:0]   x_w;
    logic signed [W:0]   y_w;

    assign x_sh = x_i >>> SHIFT;
    assign y_sh = y_i >>> SHIFT;

    // Fixed add or subtract of the shifted copy, one bit wider than the path.
    always_comb begin
        if (SUBTRACT) begin
            x_w = {x_i[W-1], x_i} - {x_sh[W-1], x_sh};
            y_w = {y_i[W-1], y_i} - {y_sh[W-1], y_sh};
        end else begin
            x_w = {x_i[W-1], x_i} + {x_sh[W-1], x_sh};
            y_w = {y_i[W-1], y_i} + {y_sh[W-1], y_sh};
        end
    end

    // Pipeline valid bit, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_o <= 1'b0;
        else        valid_o <= valid_i;
    end

    // Pipeline data register.
    always_ff @(posedge clk) begin
        mode_o <= mode_i;
        x_o    <= x_w[W-1:0];
        y_o    <= y_w[W-1:0];
        z_o    <= z_i;
    end

    function automatic logic [W:0] vmag(input logic signed [W-1:0] v);
        logic signed [W:0] e;
        e = {v[W-1], v};
        return e[W] ? -e : e;
    endfunction

    // R7: correction never overflows the guarded datapath.
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |-> (x_w[W] == x_w[W-1] && y_w[W] == y_w[W-1]));

    // R6: a subtracting stage never increases a coordinate's magnitude.
    assert_sub_shrinks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && SUBTRACT) |=> (vmag(x_o) <= vmag($past(x_i)) + 1));

endmodule

// File: rtl/cordic_pipe_array.sv
// Module: top of the unrolled rotator. Widens the inputs with guard bits,
// chains ROT_STAGES micro-rotation stages and SCALE_STAGES gain-correction
// stages, and trims the last stage to the output widths.
// Assumes the input ranges given in the brief for each mode.
module cordic_pipe_array
    import cordic_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int ANGLE_W      = 16,
    parameter int ROT_STAGES   = 16,
    parameter int FRAC_GUARD   = 4,
    parameter int ANGLE_GUARD  = 4,
    parameter int SCALE_STAGES = 6,
    parameter logic [SCALE_STAGES*5-1:0] SCALE_SHIFTS = {5'd16, 5'd10, 5'd9, 5'd5, 5'd2, 5'd1},
    parameter logic [SCALE_STAGES-1:0]   SCALE_SUB    = 6'b000101
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid_i,
    input  logic               mode_i,
    input  logic [DATA_W-1:0]  x_i,
    input  logic [DATA_W-1:0]  y_i,
    input  logic [ANGLE_W-1:0] z_i,
    output logic               valid_o,
    output logic [DATA_W:0]    x_o,
    output logic [DATA_W:0]    y_o,
    output logic [ANGLE_W-1:0] z_o
);

    localparam int W       = DATA_W + 2 + FRAC_GUARD;
    localparam int ZI      = ANGLE_W + ANGLE_GUARD;
    localparam int TOT     = ROT_STAGES + SCALE_STAGES;
    localparam int LATENCY = TOT;

    logic                 vs [0:TOT];
    cordic_mode_e         ms [0:TOT];
    logic signed [W-1:0]  xs [0:TOT];
    logic signed [W-1:0]  ys [0:TOT];
    logic signed [ZI-1:0] zs [0:TOT];

    // Sign-extends by two guard bits and appends fraction guard bits.
    always_comb begin
        vs[0] = valid_i;
        ms[0] = cordic_mode_e'(mode_i);
        xs[0] = {{2{x_i[DATA_W-1]}}, x_i, {FRAC_GUARD{1'b0}}};
        ys[0] = {{2{y_i[DATA_W-1]}}, y_i, {FRAC_GUARD{1'b0}}};
        zs[0] = {z_i, {ANGLE_GUARD{1'b0}}};
    end

    generate
        for (genvar i = 0; i < ROT_STAGES; i++) begin : g_rot
            localparam int ANG_CODE = elem_angle_code(i, ZI);
            cordic_rot_stage #(
                .W(W), .ZI(ZI), .SHIFT(i), .ANGLE(ANG_CODE)
            ) u_rot (
                .clk(clk), .rst_n(rst_n),
                .valid_i(vs[i]), .mode_i(ms[i]),
                .x_i(xs[i]), .y_i(ys[i]), .z_i(zs[i]),
                .valid_o(vs[i+1]), .mode_o(ms[i+1]),
                .x_o(xs[i+1]), .y_o(ys[i+1]), .z_o(zs[i+1])
            );
        end
        for (genvar j = 0; j < SCALE_STAGES; j++) begin : g_scale
            localparam int SH = int'(SCALE_SHIFTS[j*5 +: 5]);
            localparam int K  = ROT_STAGES + j;
            cordic_scale_stage #(
                .W(W), .ZI(ZI), .SHIFT(SH), .SUBTRACT(SCALE_SUB[j])
            ) u_scale (
                .clk(clk), .rst_n(rst_n),
                .valid_i(vs[K]), .mode_i(ms[K]),
                .x_i(xs[K]), .y_i(ys[K]), .z_i(zs[K]),
                .valid_o(vs[K+1]), .mode_o(ms[K+1]),
                .x_o(xs[K+1]), .y_o(ys[K+1]), .z_o(zs[K+1])
            );
        end
    endgenerate

    // Drops the fraction guard bits and the unused top guard bit.
    assign valid_o = vs[LATENCY];
    assign x_o     = xs[TOT][FRAC_GUARD+DATA_W:FRAC_GUARD];
    assign y_o     = ys[TOT][FRAC_GUARD+DATA_W:FRAC_GUARD];
    assign z_o     = zs[TOT][ZI-1:ANGLE_GUARD];

    // R7: the final value fits the output width without wrapping.
    assert_output_fits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (xs[TOT][W-1] == xs[TOT][W-2] && ys[TOT][W-1] == ys[TOT][W-2]));

endmodule

// File: tb/cordic_pipe_array_tb_top.sv
`timescale 1ns/1ps
module cordic_pipe_array_tb_top;

    localparam int  DW     = 16;
    localparam int  ZW     = 16;
    localparam int  LAT    = 16 + 6;
    localparam int  TOL_XY = 8;
    localparam int  TOL_Z  = 4;
    localparam real PI     = 3.14159265358979;
    localparam real ZSCALE = 32768.0;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          valid_i;
    logic          mode_i;
    logic [DW-1:0] x_i;
    logic [DW-1:0] y_i;
    logic [ZW-1:0] z_i;
    logic          valid_o;
    logic [DW:0]   x_o;
    logic [DW:0]   y_o;
    logic [ZW-1:0] z_o;

    always #10 clk = ~clk;

    cordic_pipe_array dut_i (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .mode_i(mode_i),
        .x_i(x_i), .y_i(y_i), .z_i(z_i),
        .valid_o(valid_o), .x_o(x_o), .y_o(y_o), .z_o(z_o)
    );

    typedef struct {
        int    x;
        int    y;
        int    z;
        bit    vec;
        int    edge_no;
        string tag;
    } rec_t;

    rec_t q[$];
    int   edge_cnt = 0;
    int   n_chk    = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    always @(posedge clk) edge_cnt++;

    task automatic check_int(input string req, input string what,
                             input int act, input int exp, input int tol);
        n_chk++;
        if (act - exp > tol || exp - act > tol) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (tol %0d)", req, what, act, exp, tol);
        end
    endtask

    task automatic verify(input rec_t r);
        real xr;
        real yr;
        real th;
        real xe;
        real ye;
        real ze;
        int  xa;
        int  ya;
        int  za;
        xa = int'($signed(x_o));
        ya = int'($signed(y_o));
        za = int'($signed(z_o));
        xr = real'(r.x);
        yr = real'(r.y);
        check_int("R2", "latency", edge_cnt - r.edge_no, LAT, 0);
        if (!r.vec) begin
            th = real'(r.z) * PI / ZSCALE;
            xe = xr * $cos(th) - yr * $sin(th);
            ye = yr * $cos(th) + xr * $sin(th);
            check_int(r.tag, "rotate x", xa, int'(xe), TOL_XY);
            check_int(r.tag, "rotate y", ya, int'(ye), TOL_XY);
            check_int(r.tag, "rotate z residual", za, 0, TOL_Z);
        end else begin
            xe = $sqrt(xr * xr + yr * yr);
            check_int(r.tag, "vector x", xa, int'(xe), TOL_XY);
            check_int(r.tag, "vector y", ya, 0, TOL_XY);
            if (xe >= 1024.0) begin
                ze = $atan2(yr, xr) * ZSCALE / PI;
                check_int(r.tag, "vector z", za, int'(ze), TOL_Z);
            end
        end
    endtask

    // Output monitor: pairs each valid result with the oldest pending sample.
    always @(negedge clk) begin
        rec_t r;
        if (rst_n === 1'b1 && valid_o === 1'b1 && !done) begin
            if (q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R1 unexpected valid_o: actual 1 expected 0 (R2 order)");
            end else begin
                r = q.pop_front();
                verify(r);
            end
        end
    end

    task automatic send(input bit vec, input int x, input int y, input int z, input string tag);
        rec_t r;
        @(negedge clk);
        valid_i = 1'b1;
        mode_i  = vec;
        x_i     = DW'(x);
        y_i     = DW'(y);
        z_i     = ZW'(z);
        r.x = x; r.y = y; r.z = z; r.vec = vec; r.edge_no = edge_cnt; r.tag = tag;
        q.push_back(r);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            valid_i = 1'b0;
        end
    endtask

    function automatic int rnd(input int lo, input int hi);
        return lo + int'($urandom_range(hi - lo, 0));
    endfunction

    task automatic send_random(input int mode_sel, input string tag);
        bit vec;
        if (mode_sel == 2) vec = bit'($urandom_range(1, 0));
        else               vec = bit'(mode_sel);
        if (vec) send(1'b1, rnd(0, 32767), rnd(-32768, 32767), 0, tag);
        else     send(1'b0, rnd(-32768, 32767), rnd(-32768, 32767), rnd(-16384, 16384), tag);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; valid_i = 1'b0; mode_i = 1'b0;
        x_i = '0; y_i = '0; z_i = '0;
        repeat (3) @(negedge clk);
        check_int("R1", "valid_o in reset", int'(valid_o), 0, 0);
        rst_n = 1'b1;
        idle(LAT + 2);
        check_int("R1", "valid_o idle after reset", int'(valid_o), 0, 0);

        // Directed corners: identity, quarter turns, full-scale inputs.
        send(1'b0, 20000, 0, 0, "R6");
        send(1'b0, -12345, 23456, 0, "R6");
        send(1'b0, 20000, 0, 16384, "R3");
        send(1'b0, 20000, 0, -16384, "R3");
        send(1'b0, 32767, 32767, 8192, "R7");
        send(1'b0, -32768, -32768, -16384, "R7");
        send(1'b0, -32768, 32767, 16384, "R7");
        send(1'b1, 32767, -32768, 0, "R7");
        send(1'b1, 0, 32767, 0, "R4");
        send(1'b1, 0, -32768, 0, "R4");
        send(1'b1, 30000, 0, 0, "R4");
        // Gaps in the stream keep their positions.
        idle(3);
        send(1'b0, 1000, -2000, 4000, "R2");
        idle(1);
        send(1'b1, 5000, 5000, 0, "R2");
        idle(2);
        send(1'b0, -7000, 3000, -9000, "R2");
        idle(LAT + 2);
        check_int("R2", "pending after gaps", q.size(), 0, 0);

        // Back-to-back stream with the mode changing per sample.
        for (int k = 0; k < 400; k++) send_random(2, "R5");
        for (int k = 0; k < 150; k++) send_random(0, "R3");
        for (int k = 0; k < 150; k++) send_random(1, "R4");
        idle(LAT + 2);
        check_int("R2", "pending after stream", q.size(), 0, 0);

        // Reset with the chain full: nothing from before may come out.
        for (int k = 0; k < 15; k++) send_random(2, "R5");
        @(negedge clk);
        rst_n   = 1'b0;
        valid_i = 1'b0;
        @(negedge clk);
        q.delete();
        check_int("R1", "valid_o after mid-stream reset", int'(valid_o), 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(LAT + 2);
        check_int("R1", "valid_o stays low after flush", int'(valid_o), 0, 0);

        for (int k = 0; k < 40; k++) send_random(2, "R5");
        idle(LAT + 2);
        check_int("R2", "pending at end", q.size(), 0, 0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R2: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule